// File: doc/BRIEF.md
# SCSI Bus Arbitration Controller

This block runs the initiator side of SCSI bus arbitration for a controller that the host programs through registers. The host writes a mode register bit to request arbitration and writes a select-assert bit that drives SEL onto the bus. It reads back three flags: arbitration running, arbitration lost and arbitration won. On the bus side the block drives BSY and places its own-ID byte on the 8-bit data bus. It samples the SEL line and the data bus, which are wired-OR with the other devices.

A request begins only when the arbitrate bit goes from 0 to 1. If another device already holds SEL and the host is not the one asserting it, the request fails at once and nothing is driven. Otherwise the block drives BSY and its ID, then waits a programmable number of clocks. It then samples the data bus. The highest-numbered set bit on the bus wins. On a win the block keeps BSY and the ID on the bus. On a loss it releases every line it drives.

The running flag does not clear when the decision is made. It clears only when the host writes the arbitrate bit back to 0, and that write also releases the bus. A soft reset returns the block to idle. The selection phase, target mode, interrupts and parity are handled elsewhere. Bus lines are modelled active-high, and each line has its own drive enable.

Top module: `scsi_arb_ctrl`

## Requirements
- R1: After reset, no bus line is driven (bsy_drv, sel_drv and data_oe are 0) and arb_busy, arb_lost and arb_won are all 0.
- R2: Arbitration starts only on a mode write that changes the arbitrate bit from 0 to 1. Writing 1 while the bit already holds 1 has no effect on the flags or on the bus lines.
- R3: If bus_sel_in is 1 and the stored select-assert bit is 0 when arbitration starts, arb_lost is set on the next clock. arb_busy stays 0 and no line is driven.
- R4: If the stored select-assert bit is 1, a SEL seen on the bus does not block the start, and sel_drv follows the stored select-assert bit.
- R5: When arbitration proceeds, the next clock shows arb_lost 0, arb_busy 1, bsy_drv 1, data_oe 1, and data_out equal to the own_id captured at the start write.
- R6: The decision is registered exactly ARB_DELAY clocks after the start edge, and no earlier. Arbitration is won when the highest-numbered set bit of bus_data_in is also set in the captured ID. On a win arb_won becomes 1 and BSY and the data bus stay driven.
- R7: On a loss, arb_lost becomes 1 and arb_won stays 0. bsy_drv, data_oe and sel_drv all drop to 0 in the same clock.
- R8: arb_busy stays 1 after a win or a loss. It clears only on a mode write that changes the arbitrate bit from 1 to 0. That write also clears arb_won and releases BSY and the data bus.
- R9: While soft_rst is high, the next clock returns every output to its reset state. This clears the stored arbitrate and select-assert bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| mode_wr | input | 1 | Write strobe for the arbitrate mode bit |
| mode_arb | input | 1 | Arbitrate bit value written with mode_wr |
| icmd_wr | input | 1 | Write strobe for the select-assert bit |
| icmd_sel | input | 1 | Select-assert bit value written with icmd_wr |
| own_id | input | BUS_W | ID byte placed on the bus, captured at start |
| bus_sel_in | input | 1 | Sampled SEL line (wired-OR of all devices) |
| bus_data_in | input | BUS_W | Sampled data bus (wired-OR of all devices) |
| bsy_drv | output | 1 | Drive enable that asserts BSY |
| sel_drv | output | 1 | Drive enable that asserts SEL |
| data_oe | output | 1 | Drive enable for data_out |
| data_out | output | BUS_W | Byte driven onto the data bus |
| arb_busy | output | 1 | Arbitration-running flag |
| arb_lost | output | 1 | Arbitration-lost flag |
| arb_won | output | 1 | Arbitration-won flag |

## Verification
The winner decision is swept over every one-hot own ID combined with every one of the 256 competitor bytes. This shows the difference between a win decided by the highest set bit and one decided by any overlap or by a low-bit priority. The check one clock before the delay ends shows whether the decision comes early. Separate sequences place a foreign SEL on the bus with the select-assert bit clear and then set. These show whether the conflict test looks at the correct bit. Rewriting a 1, clearing the arbitrate bit and soft reset in the middle of arbitration show whether the running flag stays set and where it is allowed to clear.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_RUN  = 2'd1,
    ARB_WON  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
  parameter int DELAY = 24,
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(DELAY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear || start)
      cnt_q <= '0;
    else if (run && !expire)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/arb_top_bit.sv
module arb_top_bit #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < W; i++)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/scsi_arb_ctrl.sv
module scsi_arb_ctrl
  import scsi_arb_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int ARB_DELAY = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             mode_wr,
  input  logic             mode_arb,
  input  logic             icmd_wr,
  input  logic             icmd_sel,
  input  logic [BUS_W-1:0] own_id,
  input  logic             bus_sel_in,
  input  logic [BUS_W-1:0] bus_data_in,
  output logic             bsy_drv,
  output logic             sel_drv,
  output logic             data_oe,
  output logic [BUS_W-1:0] data_out,
  output logic             arb_busy,
  output logic             arb_lost,
  output logic             arb_won
);
  localparam int IW = (BUS_W > 1) ? $clog2(BUS_W) : 1;

  arb_state_e       st_q;
  logic             mode_q, sel_q;
  logic [BUS_W-1:0] id_q;
  logic             bsy_q, doe_q, busy_q, lost_q, won_q;

  logic             arb_rise, arb_fall, sel_block, go;
  logic             expire;
  logic [IW-1:0]    top_idx;
  logic             top_any, own_hit;

  assign arb_rise  = mode_wr && mode_arb && !mode_q;
  assign arb_fall  = mode_wr && !mode_arb && mode_q;
  assign sel_block = bus_sel_in && !sel_q;
  assign go        = arb_rise && !sel_block && !soft_rst;

  arb_delay_timer #(.DELAY(ARB_DELAY)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (soft_rst || arb_fall),
    .start  (go),
    .run    (st_q == ARB_RUN),
    .expire (expire)
  );

  arb_top_bit #(.W(BUS_W)) u_scan (
    .vec (bus_data_in),
    .idx (top_idx),
    .any (top_any)
  );

  assign own_hit = top_any && id_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ARB_IDLE;
      mode_q <= 1'b0;
      sel_q  <= 1'b0;
      id_q   <= '0;
      bsy_q  <= 1'b0;
      doe_q  <= 1'b0;
      busy_q <= 1'b0;
      lost_q <= 1'b0;
      won_q  <= 1'b0;
    end else if (soft_rst) begin
      st_q   <= ARB_IDLE;
      mode_q <= 1'b0;
      sel_q  <= 1'b0;
      bsy_q  <= 1'b0;
      doe_q  <= 1'b0;
      busy_q <= 1'b0;
      lost_q <= 1'b0;
      won_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_arb;
      if (icmd_wr) sel_q  <= icmd_sel;
      if (arb_fall) begin
        st_q   <= ARB_IDLE;
        busy_q <= 1'b0;
        won_q  <= 1'b0;
        bsy_q  <= 1'b0;
        doe_q  <= 1'b0;
      end else if (arb_rise) begin
        if (sel_block) begin
          lost_q <= 1'b1;
        end else begin
          st_q   <= ARB_RUN;
          lost_q <= 1'b0;
          busy_q <= 1'b1;
          bsy_q  <= 1'b1;
          doe_q  <= 1'b1;
          id_q   <= own_id;
        end
      end else if (st_q == ARB_RUN && expire) begin
        if (own_hit) begin
          st_q  <= ARB_WON;
          won_q <= 1'b1;
        end else begin
          st_q   <= ARB_IDLE;
          lost_q <= 1'b1;
          bsy_q  <= 1'b0;
          doe_q  <= 1'b0;
          sel_q  <= 1'b0;
        end
      end
    end
  end

  assign bsy_drv  = bsy_q;
  assign sel_drv  = sel_q;
  assign data_oe  = doe_q;
  assign data_out = id_q;
  assign arb_busy = busy_q;
  assign arb_lost = lost_q;
  assign arb_won  = won_q;
endmodule

// File: rtl/scsi_arb_chk.sv
module scsi_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic mode_wr,
  input logic mode_arb,
  input logic bsy_drv,
  input logic sel_drv,
  input logic data_oe,
  input logic arb_busy,
  input logic arb_lost,
  input logic arb_won
);
  // R5
  start_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_busy) |-> bsy_drv && data_oe && !arb_lost);

  // R6
  win_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won |-> bsy_drv && data_oe && !arb_lost);

  // R6
  win_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_won) |-> $past(arb_busy));

  // R7
  loss_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !bsy_drv && !data_oe && !arb_won);

  // R8
  busy_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_busy) |-> $past(soft_rst) || ($past(mode_wr) && !$past(mode_arb)));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !bsy_drv && !sel_drv && !data_oe && !arb_busy && !arb_lost && !arb_won);
endmodule

bind scsi_arb_ctrl scsi_arb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .mode_wr  (mode_wr),
  .mode_arb (mode_arb),
  .bsy_drv  (bsy_drv),
  .sel_drv  (sel_drv),
  .data_oe  (data_oe),
  .arb_busy (arb_busy),
  .arb_lost (arb_lost),
  .arb_won  (arb_won)
);

// File: tb/sim_scsi_arb_ctrl.sv
`timescale 1ns/1ps
module sim_scsi_arb_ctrl;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic mode_wr = 1'b0, mode_arb = 1'b0;
  logic icmd_wr = 1'b0, icmd_sel = 1'b0;
  logic [W-1:0] own_id = '0;
  logic [W-1:0] comp_data = '0;
  logic comp_sel = 1'b0;
  logic bus_sel_in;
  logic [W-1:0] bus_data_in;
  logic bsy_drv, sel_drv, data_oe, arb_busy, arb_lost, arb_won;
  logic [W-1:0] data_out;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign bus_data_in = (data_oe ? data_out : '0) | comp_data;
  assign bus_sel_in  = sel_drv | comp_sel;

  scsi_arb_ctrl #(.BUS_W(W), .ARB_DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .mode_wr(mode_wr), .mode_arb(mode_arb),
    .icmd_wr(icmd_wr), .icmd_sel(icmd_sel), .own_id(own_id),
    .bus_sel_in(bus_sel_in), .bus_data_in(bus_data_in),
    .bsy_drv(bsy_drv), .sel_drv(sel_drv), .data_oe(data_oe),
    .data_out(data_out), .arb_busy(arb_busy), .arb_lost(arb_lost),
    .arb_won(arb_won)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mode_write(input logic v);
    @(negedge clk);
    mode_wr = 1'b1; mode_arb = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic icmd_write(input logic v);
    @(negedge clk);
    icmd_wr = 1'b1; icmd_sel = v;
    @(negedge clk);
    icmd_wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    idle_cycles(2);
    // R1 reset state
    chk("R1", "bsy_drv", int'(bsy_drv), 0);
    chk("R1", "sel_drv", int'(sel_drv), 0);
    chk("R1", "data_oe", int'(data_oe), 0);
    chk("R1", "flags", int'({arb_busy, arb_lost, arb_won}), 0);
    rst_n = 1'b1;
    idle_cycles(2);
    chk("R1", "flags after release", int'({arb_busy, arb_lost, arb_won, bsy_drv}), 0);

    // R6 sweep: every one-hot own ID against every competitor byte
    for (int o = 0; o < W; o++) begin
      for (int c = 0; c < 256; c++) begin
        int expw;
        expw = ((c >> (o + 1)) == 0) ? 1 : 0;
        own_id = W'(1 << o);
        comp_data = W'(c);
        mode_write(1'b1);
        // R5 start drives BSY and ID
        chk("R5", "busy", int'(arb_busy), 1);
        chk("R5", "bsy_drv", int'(bsy_drv), 1);
        chk("R5", "data", int'(data_oe ? data_out : 8'h00), 1 << o);
        chk("R5", "lost clear", int'(arb_lost), 0);
        idle_cycles(D - 1);
        chk("R6", "no early decision", int'(arb_won | arb_lost), 0);
        idle_cycles(1);
        chk("R6", "won", int'(arb_won), expw);
        chk("R7", "lost", int'(arb_lost), 1 - expw);
        chk("R7", "bsy after decision", int'(bsy_drv), expw);
        chk("R7", "data_oe after decision", int'(data_oe), expw);
        chk("R8", "busy sticky", int'(arb_busy), 1);
        mode_write(1'b0);
        chk("R8", "busy cleared", int'(arb_busy), 0);
        chk("R8", "released", int'({bsy_drv, data_oe, arb_won}), 0);
      end
    end
    comp_data = '0;

    // R2 rewrite of 1 after a win has no effect
    own_id = 8'h40;
    mode_write(1'b1);
    idle_cycles(D);
    chk("R2", "won before rewrite", int'(arb_won), 1);
    comp_data = 8'h80;
    mode_write(1'b1);
    idle_cycles(D + 2);
    chk("R2", "won kept after rewrite", int'(arb_won), 1);
    chk("R2", "lost after rewrite", int'(arb_lost), 0);
    chk("R2", "bsy kept after rewrite", int'(bsy_drv), 1);
    mode_write(1'b0);
    comp_data = '0;

    // R3 foreign SEL blocks the start
    comp_sel = 1'b1;
    own_id = 8'h02;
    mode_write(1'b1);
    chk("R3", "lost", int'(arb_lost), 1);
    chk("R3", "busy", int'(arb_busy), 0);
    chk("R3", "driven", int'({bsy_drv, data_oe, sel_drv}), 0);
    comp_sel = 1'b0;
    idle_cycles(D + 1);
    chk("R3", "still not driven", int'({bsy_drv, data_oe}), 0);
    // R2 bit already 1: rewriting does not start
    mode_write(1'b1);
    idle_cycles(1);
    chk("R2", "no start on rewrite", int'({arb_busy, bsy_drv}), 0);
    mode_write(1'b0);
    mode_write(1'b1);
    chk("R2", "start after 0 then 1", int'(arb_busy), 1);
    chk("R5", "lost cleared on start", int'(arb_lost), 0);
    idle_cycles(D);
    mode_write(1'b0);

    // R4 own SEL does not block; R7 loss releases SEL
    icmd_write(1'b1);
    chk("R4", "sel_drv follows bit", int'(sel_drv), 1);
    comp_sel = 1'b1;
    comp_data = 8'h80;
    own_id = 8'h01;
    mode_write(1'b1);
    chk("R4", "busy with own SEL", int'(arb_busy), 1);
    chk("R4", "lost with own SEL", int'(arb_lost), 0);
    idle_cycles(D);
    chk("R7", "lost", int'(arb_lost), 1);
    chk("R7", "sel released", int'(sel_drv), 0);
    chk("R7", "bsy released", int'(bsy_drv), 0);
    comp_sel = 1'b0;
    comp_data = '0;
    mode_write(1'b0);

    // R9 soft reset mid-arbitration
    icmd_write(1'b1);
    own_id = 8'h10;
    mode_write(1'b1);
    idle_cycles(1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R9", "lines", int'({bsy_drv, sel_drv, data_oe}), 0);
    chk("R9", "flags", int'({arb_busy, arb_lost, arb_won}), 0);
    idle_cycles(D + 1);
    chk("R9", "stays idle", int'({arb_won, bsy_drv}), 0);
    mode_write(1'b1);
    chk("R9", "mode bit cleared so start works", int'(arb_busy), 1);
    idle_cycles(D);
    chk("R6", "win after soft reset", int'(arb_won), 1);
    mode_write(1'b0);

    summary();
    $finish;
  end
endmodule